// File: doc/BRIEF.md
# Dynamic Bus Sizing Sequencer

This block sits between a 32-bit processor core and a 16-bit external data bus. The core hands it one aligned access at a time: a byte, a 16-bit word or a 32-bit long word, for either a read or a write. The block runs as many external bus cycles as the access needs. At the start of each cycle it drives the address and a two-bit code for the bytes still outstanding. The responding slave returns a two-bit acknowledge that gives its port width. The block uses that width to decide how many bytes the cycle moved and therefore what the next cycle must carry.

Two cycle kinds are supported. A regular cycle is handshaked: it lasts at least three clocks and stretches while the acknowledge stays idle. A fast cycle lasts two clocks plus a per-request number of wait clocks. It is ended by an acknowledge made inside the block, and the port width for it comes with the request. Read bytes are collected into a 32-bit result, right-justified by the request size, and handed back with a one-clock completion strobe. Requests with an illegal alignment or size finish at once with an error and cause no bus activity.

Top module: `bus_sizer`

## Requirements
- R1: A request with `reqSize` = 11, or a word (10) or long word (00) request at an odd address, starts no bus cycle. `done` and `doneErr` are high together in the clock after the request is taken.
- R2: While a cycle is active, `busSize` encodes the bytes still outstanding: 4 gives 00, 3 gives 11, 2 gives 10 and 1 gives 01. The code is held for the whole cycle.
- R3: `ackIn` = 10 marks an 8-bit port, which moves one byte on bits 15:8. `ackIn` = 01 marks a 16-bit port, which moves two bytes at an even address when at least two remain, and one byte otherwise. The outstanding count falls by the number of bytes moved.
- R4: The address of each following cycle is the previous address plus the number of bytes the previous cycle moved.
- R5: A regular cycle keeps `busActive` high for 3 clocks when the acknowledge arrives in its second clock. Each clock of `ackIn` = 00 from the second clock on adds one clock.
- R6: A fast request (`reqFast`=1) runs cycles of 2 + `reqWaits` clocks each, with port width 16 bits when `reqPort16`=1 and 8 bits otherwise. `ackIn` is ignored throughout.
- R7: On writes, an even-address cycle drives the next operand byte on bits 15:8 and the byte after it on bits 7:0. An odd-address cycle drives the same byte on both lanes.
- R8: On reads, an 8-bit port byte is taken from bits 15:8. A 16-bit port odd-address byte is taken from bits 7:0. Lanes carrying no operand byte do not affect the result.
- R9: `done` is a one-clock pulse in the clock after the last portion completes. `rdata` then holds the read bytes right-justified, with the first-transferred byte most significant.
- R10: `ackIn` = 11 ends the request after that cycle, with `done` and `doneErr` both high, and no further cycle is started.
- R11: `reqReady` is low from the clock after a request is taken until the request finishes. Requests offered meanwhile are ignored.
- R12: The three-byte code appears only when a long word goes to an 8-bit port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Sequencer idle; request taken when both high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | 01 byte, 10 word, 00 long word |
| reqAddr | input | AW | Byte address of the operand |
| reqWdata | input | 32 | Write operand, right-justified |
| reqFast | input | 1 | Use fast internally terminated cycles |
| reqPort16 | input | 1 | Port width for fast cycles: 1 = 16-bit |
| reqWaits | input | WW | Wait clocks per fast cycle |
| done | output | 1 | Request finished (one clock) |
| doneErr | output | 1 | Request rejected or bus error, valid with done |
| rdata | output | 32 | Assembled read data, valid with done |
| busActive | output | 1 | External cycle in progress |
| busStart | output | 1 | First clock of a cycle |
| busRw | output | 1 | 1 = read cycle |
| busSize | output | 2 | Outstanding-size code |
| busAddr | output | AW | Cycle address |
| busDout | output | 16 | Write data lanes |
| busDin | input | 16 | Read data lanes |
| ackIn | input | 2 | Port-size acknowledge from the slave |

## Verification
The properties assume that the slave changes `ackIn` only between clock edges and that a cycle's address and size seen at `busStart` describe the whole cycle. The bench slave drives its acknowledge and data on falling edges from a byte memory model. It gives each cycle at most one acknowledge, after a programmed number of idle clocks, and withdraws it afterwards. Unused read lanes carry fixed filler bytes, and during fast tests the slave drives the error code on `ackIn` so that ignoring it is exercised.

// File: rtl/bsz_pkg.sv
package bsz_pkg;

  localparam int OPW = 32;
  localparam int LANEW = 16;
  localparam int NBYTES = OPW / 8;

  localparam logic [1:0] SZ_LONG = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
  localparam logic [1:0] SZ_TRIP = 2'b11;

  localparam logic [1:0] ACK_IDLE = 2'b00;
  localparam logic [1:0] ACK_P16 = 2'b01;
  localparam logic [1:0] ACK_P8 = 2'b10;
  localparam logic [1:0] ACK_ERR = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_TERM,
    ST_FAST,
    ST_DONE
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic capture;
    logic advance;
    logic useNow;
    logic port16;
  } seqCtl_t;

  function automatic logic [2:0] sizeToBytes(input logic [1:0] code);
    case (code)
      SZ_BYTE: return 3'd1;
      SZ_WORD: return 3'd2;
      SZ_TRIP: return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] bytesToSize(input logic [2:0] cnt);
    case (cnt)
      3'd4: return SZ_LONG;
      3'd3: return SZ_TRIP;
      3'd2: return SZ_WORD;
      default: return SZ_BYTE;
    endcase
  endfunction

endpackage

// File: rtl/bsz_ctrl.sv
module bsz_ctrl
  import bsz_pkg::*;
#(
  parameter int WW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic [1:0]    reqSize,
  input  logic          reqAddr0,
  input  logic          reqFast,
  input  logic          reqPort16,
  input  logic [WW-1:0] reqWaits,
  input  logic [1:0]    ackIn,
  input  logic          lastNow,
  output seqCtl_t       ctl,
  output logic          reqReady,
  output logic          busActive,
  output logic          busStart,
  output logic          busRw,
  output logic          done,
  output logic          doneErr
);

  seqState_e state, stateNext;
  logic isWrite;
  logic fastMode;
  logic fastP16;
  logic [WW-1:0] waitLim;
  logic [WW-1:0] waitCnt;
  logic errFlag;
  logic badReq;
  logic take;
  logic fastHit;

  assign badReq = (reqSize == SZ_TRIP) || ((reqSize != SZ_BYTE) && reqAddr0);
  assign take = (state == ST_IDLE) && reqValid;
  assign fastHit = (state == ST_FAST) && (waitCnt == waitLim);

  always_comb begin
    ctl = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.load = !badReq;
          stateNext = badReq ? ST_DONE : ST_ADDR;
        end
      end
      ST_ADDR: stateNext = fastMode ? ST_FAST : ST_WAIT;
      ST_WAIT: begin
        if (ackIn == ACK_ERR) begin
          stateNext = ST_TERM;
        end else if (ackIn != ACK_IDLE) begin
          ctl.capture = 1'b1;
          ctl.port16 = (ackIn == ACK_P16);
          stateNext = ST_TERM;
        end
      end
      ST_TERM: begin
        if (errFlag) begin
          stateNext = ST_DONE;
        end else begin
          ctl.advance = 1'b1;
          stateNext = lastNow ? ST_DONE : ST_ADDR;
        end
      end
      ST_FAST: begin
        ctl.port16 = fastP16;
        if (fastHit) begin
          ctl.capture = 1'b1;
          ctl.advance = 1'b1;
          ctl.useNow = 1'b1;
          stateNext = lastNow ? ST_DONE : ST_ADDR;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      isWrite <= 1'b0;
      fastMode <= 1'b0;
      fastP16 <= 1'b0;
      waitLim <= '0;
      waitCnt <= '0;
      errFlag <= 1'b0;
    end else begin
      state <= stateNext;
      if (take) begin
        isWrite <= reqWrite;
        fastMode <= reqFast;
        fastP16 <= reqPort16;
        waitLim <= reqWaits;
        errFlag <= badReq;
      end
      if ((state == ST_WAIT) && (ackIn == ACK_ERR)) begin
        errFlag <= 1'b1;
      end
      if (state == ST_ADDR) begin
        waitCnt <= '0;
      end else if ((state == ST_FAST) && !fastHit) begin
        waitCnt <= waitCnt + 1'b1;
      end
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign busStart = (state == ST_ADDR);
  assign busActive = (state == ST_ADDR) || (state == ST_WAIT) ||
                     (state == ST_TERM) || (state == ST_FAST);
  assign busRw = !isWrite;
  assign done = (state == ST_DONE);
  assign doneErr = (state == ST_DONE) && errFlag;

endmodule

// File: rtl/bsz_datapath.sv
module bsz_datapath
  import bsz_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtl_t          ctl,
  input  logic [1:0]       reqSize,
  input  logic [AW-1:0]    reqAddr,
  input  logic [OPW-1:0]   reqWdata,
  input  logic [LANEW-1:0] busDin,
  output logic [AW-1:0]    busAddr,
  output logic [1:0]       busSize,
  output logic [LANEW-1:0] busDout,
  output logic [OPW-1:0]   rdata,
  output logic             lastNow
);

  localparam int IDXW = $clog2(NBYTES);

  logic [AW-1:0] addrReg;
  logic [2:0] remReg;
  logic [2:0] origReg;
  logic [1:0] accReg;
  logic [7:0] wB [NBYTES];
  logic [7:0] rB [NBYTES];
  logic [OPW-1:0] wAligned;
  logic [OPW-1:0] rPacked;
  logic [2:0] reqBytes;
  logic [IDXW-1:0] off;
  logic [IDXW-1:0] offNext;
  logic a0;
  logic wideTwo;
  logic [1:0] accNow;
  logic [1:0] accSel;
  logic [7:0] firstVal;

  assign reqBytes = sizeToBytes(reqSize);
  assign off = IDXW'(origReg - remReg);
  assign offNext = off + 1'b1;
  assign a0 = addrReg[0];
  assign wideTwo = ctl.port16 && !a0 && (remReg >= 3'd2);
  assign accNow = wideTwo ? 2'd2 : 2'd1;
  assign accSel = ctl.useNow ? accNow : accReg;
  assign lastNow = ({1'b0, accSel} == remReg);
  assign firstVal = (ctl.port16 && a0) ? busDin[7:0] : busDin[15:8];

  // write operand shifted so its first byte sits in the top lane
  assign wAligned = reqWdata << (6'(8) * (6'(NBYTES) - 6'(reqBytes)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      remReg <= '0;
      origReg <= '0;
      accReg <= 2'd1;
    end else if (ctl.load) begin
      addrReg <= reqAddr;
      remReg <= reqBytes;
      origReg <= reqBytes;
      accReg <= 2'd1;
    end else begin
      if (ctl.capture) accReg <= accNow;
      if (ctl.advance) begin
        addrReg <= addrReg + AW'(accSel);
        remReg <= remReg - {1'b0, accSel};
      end
    end
  end

  for (genvar gi = 0; gi < NBYTES; gi++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rstN) begin
        wB[gi] <= '0;
        rB[gi] <= '0;
      end else if (ctl.load) begin
        wB[gi] <= wAligned[OPW-1-8*gi -: 8];
        rB[gi] <= '0;
      end else if (ctl.capture) begin
        if (off == IDXW'(gi)) begin
          rB[gi] <= firstVal;
        end else if (wideTwo && (offNext == IDXW'(gi))) begin
          rB[gi] <= busDin[7:0];
        end
      end
    end
    assign rPacked[OPW-1-8*gi -: 8] = rB[gi];
  end

  assign rdata = rPacked >> (6'(8) * (6'(NBYTES) - 6'(origReg)));
  assign busAddr = addrReg;
  assign busSize = bytesToSize(remReg);
  assign busDout = {wB[off], (a0 || (remReg < 3'd2)) ? wB[off] : wB[offNext]};

endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
  import bsz_pkg::*;
#(
  parameter int AW = 24,
  parameter int WW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic          reqWrite,
  input  logic [1:0]    reqSize,
  input  logic [AW-1:0] reqAddr,
  input  logic [31:0]   reqWdata,
  input  logic          reqFast,
  input  logic          reqPort16,
  input  logic [WW-1:0] reqWaits,
  output logic          done,
  output logic          doneErr,
  output logic [31:0]   rdata,
  output logic          busActive,
  output logic          busStart,
  output logic          busRw,
  output logic [1:0]    busSize,
  output logic [AW-1:0] busAddr,
  output logic [15:0]   busDout,
  input  logic [15:0]   busDin,
  input  logic [1:0]    ackIn
);

  seqCtl_t ctl;
  logic lastNow;

  bsz_ctrl #(.WW(WW)) ctrlInst (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr0(reqAddr[0]), .reqFast(reqFast),
    .reqPort16(reqPort16), .reqWaits(reqWaits), .ackIn(ackIn),
    .lastNow(lastNow), .ctl(ctl), .reqReady(reqReady),
    .busActive(busActive), .busStart(busStart), .busRw(busRw),
    .done(done), .doneErr(doneErr)
  );

  bsz_datapath #(.AW(AW)) dpInst (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqSize(reqSize),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .busDin(busDin),
    .busAddr(busAddr), .busSize(busSize), .busDout(busDout),
    .rdata(rdata), .lastNow(lastNow)
  );

endmodule

// File: rtl/bsz_chk.sv
module bsz_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqReady,
  input logic [1:0] reqSize,
  input logic       reqAddr0,
  input logic       busActive,
  input logic       busStart,
  input logic [1:0] busSize,
  input logic       busAddr0,
  input logic       done,
  input logic       doneErr
);

  // R1
  illegal_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && ((reqSize == 2'b11) || ((reqSize != 2'b01) && reqAddr0))
    |=> done && doneErr && !busActive);

  // R11
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    busActive |-> !reqReady);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  done_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busActive);

  // R12
  trip_odd_chk: assert property (@(posedge clk) disable iff (!rstN)
    busActive && (busSize == 2'b11) |-> busAddr0);

  // R2
  long_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    busActive && (busSize == 2'b00) |-> !busAddr0);

  // R5
  min_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    busStart |=> busActive && !busStart);

  // R2
  size_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busActive && !busStart && $past(busActive) |-> $stable(busSize) && $stable(busAddr0));

endmodule

bind bus_sizer bsz_chk chkInst (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqSize(reqSize), .reqAddr0(reqAddr[0]), .busActive(busActive),
  .busStart(busStart), .busSize(busSize), .busAddr0(busAddr[0]),
  .done(done), .doneErr(doneErr)
);

// File: tb/bus_sizer_test.sv
module bus_sizer_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic reqWrite = 1'b0;
  logic [1:0] reqSize = 2'b01;
  logic [23:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic reqFast = 1'b0;
  logic reqPort16 = 1'b0;
  logic [2:0] reqWaits = '0;
  logic done, doneErr;
  logic [31:0] rdata;
  logic busActive, busStart, busRw;
  logic [1:0] busSize;
  logic [23:0] busAddr;
  logic [15:0] busDout;
  logic [15:0] busDin;
  logic [1:0] ackIn = 2'b00;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  bus_sizer uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqSize(reqSize), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqFast(reqFast), .reqPort16(reqPort16),
    .reqWaits(reqWaits), .done(done), .doneErr(doneErr), .rdata(rdata),
    .busActive(busActive), .busStart(busStart), .busRw(busRw),
    .busSize(busSize), .busAddr(busAddr), .busDout(busDout),
    .busDin(busDin), .ackIn(ackIn)
  );

  // slave model
  logic [7:0] mem [256];
  bit slvWide = 1'b0;
  int slvMode = 0; // 0 normal ack, 1 bus error, 2 silent (drives 11)
  int slvWaits = 0;
  int nCyc = 0;
  logic [23:0] logAddr [8];
  logic [1:0] logSize [8];
  logic [15:0] logDout [8];
  int kCnt = 0;
  bit given = 1'b0;

  function automatic logic [7:0] initByte(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  assign busDin = slvWide ?
      (busAddr[0] ? {8'hEE, mem[busAddr[7:0]]} : {mem[busAddr[7:0]], mem[8'(busAddr[7:0] + 8'd1)]}) :
      {mem[busAddr[7:0]], 8'hC3};

  always @(negedge clk) begin
    if (busStart) begin
      if (nCyc < 8) begin
        logAddr[nCyc] = busAddr;
        logSize[nCyc] = busSize;
        logDout[nCyc] = busDout;
      end
      nCyc = nCyc + 1;
      kCnt = 0;
      given = 1'b0;
      ackIn = (slvMode == 2) ? 2'b11 : 2'b00;
    end else if (busActive && slvMode != 2) begin
      if (!given && kCnt == slvWaits) begin
        given = 1'b1;
        ackIn = (slvMode == 1) ? 2'b11 : (slvWide ? 2'b01 : 2'b10);
        if (!busRw && slvMode == 0) begin
          if (!slvWide) mem[busAddr[7:0]] = busDout[15:8];
          else if (busAddr[0]) mem[busAddr[7:0]] = busDout[7:0];
          else begin
            mem[busAddr[7:0]] = busDout[15:8];
            if (busSize != 2'b01) mem[8'(busAddr[7:0] + 8'd1)] = busDout[7:0];
          end
        end
      end else begin
        ackIn = 2'b00;
      end
      kCnt = kCnt + 1;
    end else begin
      ackIn = (slvMode == 2) ? 2'b11 : 2'b00;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int lat;
  bit gotErr;
  logic [31:0] gotData;
  bit readyBad;

  task automatic doReq(input bit wr, input logic [1:0] sz, input logic [23:0] a,
                       input logic [31:0] wd, input bit fast, input bit p16,
                       input int wt, input bit intr);
    bit seen;
    nCyc = 0;
    readyBad = 1'b0;
    seen = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqSize = sz; reqAddr = a; reqWdata = wd;
    reqFast = fast; reqPort16 = p16; reqWaits = 3'(wt);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    for (int n = 1; n <= 400; n++) begin
      lat = n;
      if (done) begin
        gotErr = doneErr;
        gotData = rdata;
        seen = 1'b1;
        break;
      end
      if (reqReady) readyBad = 1'b1;
      if (intr && n == 3) begin
        reqValid = 1'b1; reqWrite = 1'b1; reqSize = 2'b01;
        reqAddr = 24'h0000E0; reqWdata = 32'hFF;
      end else if (intr && n == 4) begin
        reqValid = 1'b0;
      end
      @(negedge clk);
    end
    chk(seen, "R9 done seen", 32'(seen), 1);
    @(negedge clk);
  endtask

  function automatic logic [31:0] memWord(input int a, input int nb);
    logic [31:0] v = '0;
    for (int k = 0; k < nb; k++) v = {v[23:0], mem[a + k]};
    return v;
  endfunction

  task automatic testReset();
    chk(reqReady === 1'b1, "R11 reset ready", 32'(reqReady), 1);
    chk(busActive === 1'b0, "R5 reset bus idle", 32'(busActive), 0);
    chk(done === 1'b0, "R9 reset done low", 32'(done), 0);
  endtask

  task automatic testLong16();
    slvWide = 1; slvMode = 0; slvWaits = 0;
    doReq(0, 2'b00, 24'h40, 0, 0, 0, 0, 0);
    chk(gotData == memWord(8'h40, 4), "R9 long read 16-bit data", gotData, memWord(8'h40, 4));
    chk(nCyc == 2, "R3 two word cycles", 32'(nCyc), 2);
    chk(logSize[0] == 2'b00 && logSize[1] == 2'b10, "R2 sizes long then word", {logSize[0], logSize[1]}, 4'b0010);
    chk(logAddr[1] == 24'h42, "R4 address step two", logAddr[1], 24'h42);
    chk(lat == 7, "R5 regular latency", lat, 7);
    chk(!readyBad, "R11 ready low while busy", 32'(readyBad), 0);
  endtask

  task automatic testLong8();
    slvWide = 0; slvMode = 0; slvWaits = 0;
    doReq(0, 2'b00, 24'h50, 0, 0, 0, 0, 0);
    chk(gotData == memWord(8'h50, 4), "R8 long read 8-bit data", gotData, memWord(8'h50, 4));
    chk(nCyc == 4, "R3 four byte cycles", 32'(nCyc), 4);
    chk({logSize[0], logSize[1], logSize[2], logSize[3]} == 8'b00111001, "R12 sizes 00 11 10 01",
        {logSize[0], logSize[1], logSize[2], logSize[3]}, 8'b00111001);
    chk(logAddr[3] == 24'h53 && logAddr[2] == 24'h52, "R4 byte address steps", logAddr[3], 24'h53);
    chk(lat == 13, "R5 four cycle latency", lat, 13);
  endtask

  task automatic testWord8();
    slvWide = 0; slvMode = 0; slvWaits = 0;
    doReq(0, 2'b10, 24'h60, 0, 0, 0, 0, 0);
    chk(gotData == memWord(8'h60, 2), "R9 word read right-justified", gotData, memWord(8'h60, 2));
    chk({logSize[0], logSize[1]} == 4'b1001, "R2 word on 8-bit sizes", {logSize[0], logSize[1]}, 4'b1001);
  endtask

  task automatic testOddBytes();
    slvWide = 1; slvMode = 0; slvWaits = 0;
    doReq(0, 2'b01, 24'h71, 0, 0, 0, 0, 0);
    chk(gotData == 32'(mem[8'h71]), "R8 odd byte 16-bit from low lane", gotData, 32'(mem[8'h71]));
    chk(lat == 4 && nCyc == 1, "R5 byte single cycle", lat, 4);
    slvWide = 0;
    doReq(0, 2'b01, 24'h73, 0, 0, 0, 0, 0);
    chk(gotData == 32'(mem[8'h73]), "R8 odd byte 8-bit from high lane", gotData, 32'(mem[8'h73]));
  endtask

  task automatic testWaits();
    slvWide = 1; slvMode = 0; slvWaits = 2;
    doReq(0, 2'b10, 24'h80, 0, 0, 0, 0, 0);
    chk(lat == 6, "R5 two wait states", lat, 6);
    chk(gotData == memWord(8'h80, 2), "R3 word on 16-bit after waits", gotData, memWord(8'h80, 2));
    slvWaits = 0;
  endtask

  task automatic testWrites();
    slvWide = 0; slvMode = 0; slvWaits = 0;
    doReq(1, 2'b00, 24'h90, 32'hA1B2C3D4, 0, 0, 0, 0);
    chk(memWord(8'h90, 4) == 32'hA1B2C3D4, "R7 long write to 8-bit", memWord(8'h90, 4), 32'hA1B2C3D4);
    chk(logDout[1][15:8] == 8'hB2, "R7 second byte on high lane", 32'(logDout[1][15:8]), 8'hB2);
    slvWide = 1;
    doReq(1, 2'b10, 24'hA0, 32'h5566, 0, 0, 0, 0);
    chk(memWord(8'hA0, 2) == 32'h5566, "R7 word write to 16-bit", memWord(8'hA0, 2), 32'h5566);
    doReq(1, 2'b01, 24'hA5, 32'h7E, 0, 0, 0, 0);
    chk(mem[8'hA5] == 8'h7E && mem[8'hA4] == initByte(8'hA4), "R7 odd byte write", 32'(mem[8'hA5]), 8'h7E);
    chk(logDout[0] == 16'h7E7E, "R7 odd byte on both lanes", 32'(logDout[0]), 16'h7E7E);
  endtask

  task automatic testReject();
    slvWide = 1; slvMode = 0;
    doReq(0, 2'b10, 24'hB1, 0, 0, 0, 0, 0);
    chk(gotErr && lat == 1 && nCyc == 0, "R1 odd word rejected", {lat[7:0], 8'(nCyc), 8'(gotErr)}, 32'h010001);
    doReq(0, 2'b00, 24'hB3, 0, 0, 0, 0, 0);
    chk(gotErr && nCyc == 0, "R1 odd long rejected", 32'(nCyc), 0);
    doReq(0, 2'b11, 24'hB0, 0, 0, 0, 0, 0);
    chk(gotErr && lat == 1 && nCyc == 0, "R1 three-byte request rejected", lat, 1);
  endtask

  task automatic testBusErr();
    slvWide = 1; slvMode = 1;
    doReq(0, 2'b00, 24'hC0, 0, 0, 0, 0, 0);
    chk(gotErr, "R10 error flagged", 32'(gotErr), 1);
    chk(nCyc == 1 && lat == 4, "R10 no further cycle", 32'(nCyc), 1);
    slvMode = 0;
    doReq(0, 2'b01, 24'hC0, 0, 0, 0, 0, 0);
    chk(!gotErr, "R10 error cleared next request", 32'(gotErr), 0);
  endtask

  task automatic testFast();
    slvWide = 1; slvMode = 2;
    doReq(0, 2'b00, 24'hD0, 0, 1, 1, 0, 0);
    chk(lat == 5 && nCyc == 2, "R6 fast long 16-bit latency", lat, 5);
    chk(gotData == memWord(8'hD0, 4) && !gotErr, "R6 fast data, ack ignored", gotData, memWord(8'hD0, 4));
    slvWide = 0;
    doReq(0, 2'b01, 24'hD3, 0, 1, 0, 3, 0);
    chk(lat == 6, "R6 fast with three waits", lat, 6);
    chk(gotData == 32'(mem[8'hD3]), "R6 fast 8-bit byte", gotData, 32'(mem[8'hD3]));
    slvMode = 0;
  endtask

  task automatic testBusyIgnore();
    slvWide = 0; slvMode = 0;
    doReq(0, 2'b00, 24'h50, 0, 0, 0, 0, 1);
    repeat (6) @(negedge clk);
    chk(nCyc == 4, "R11 no extra cycles", 32'(nCyc), 4);
    chk(mem[8'hE0] == initByte(8'hE0), "R11 busy request ignored", 32'(mem[8'hE0]), 32'(initByte(8'hE0)));
  endtask

  initial begin
    #1_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = initByte(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLong16();
    testLong8();
    testWord8();
    testOddBytes();
    testWaits();
    testWrites();
    testReject();
    testBusErr();
    testFast();
    testBusyIgnore();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule